// File: doc/BRIEF.md
# Pseudo-SRAM Deep Power-Down Sequencer

This block sits on the controller side of a cellular pseudo-SRAM and moves the memory into and out of its deepest low-power state. It keeps a local shadow of the memory's refresh configuration register. That shadow holds the enable for the deep power-down state, the partial-array refresh selection and the temperature-compensated refresh range. The block decodes the array selection into the number of words that keep being refreshed.

The host asks for entry or exit with single-cycle pulses. Entry is honoured only if the shadow already has the enable bit set. The sequencer then drives the active-low sleep pin low and keeps it low for the minimum hold time. It releases the pin only on an exit request, and it then waits out the recovery guard window. From the moment the pin goes low until recovery ends, host commands are stalled and the memory sees only deselect. Because self-refresh stops during the low-power state, a sticky flag tells the host that the array contents are gone.

All times are turned into clock cycles from a clock-frequency parameter and rounded up to whole cycles. The entry hold gets one extra cycle so that it strictly exceeds its minimum.

Top module: `psram_dpd_seq`

## Requirements
- R1: After reset, `zz_n`=1, `busy`=0, `data_invalid`=0, `dpd_refused`=0, `host_cmd_ready`=1, and `rcr_q` equals the reset value (default 00h: full array, lowest temperature range, power-down disabled).
- R2: A `cfg_wr` while `busy`=0 loads `cfg_wdata` into `rcr_q` at the next edge. Bit 4 is the power-down enable, bits 2..0 are the array selection and bits 6..5 are the temperature field, which appears on `tcsr_sel`. Bits 3 and 7 are stored unchanged.
- R3: `refr_words` equals 2^ADDR_W >> n for array code n = 0..3 and 0 for codes 4..7. With ADDR_W=21, code 010 gives 080000h words, which are addresses 000000h..07FFFFh.
- R4: An entry request while the enable bit is 0 raises `dpd_refused` for exactly the next cycle and leaves `zz_n` high.
- R5: An entry request while not busy and with the enable bit set drives `zz_n` low and `busy` high from the next cycle. `zz_n` stays low for ENTRY_CYC = ceil(ENTRY_US·CLK_HZ/10^6)+1 cycles before the power-down state is reached.
- R6: While `busy`=0, `mem_cmd_valid` follows `host_cmd_valid`, `mem_cmd` follows `host_cmd`, and `host_cmd_ready`=1.
- R7: While `busy`=1, `host_cmd_ready`=0, `mem_cmd_valid`=0 and `mem_cmd`=0 (deselect). The request is stalled, not dropped.
- R8: An exit request in the power-down state drives `zz_n` high from the next cycle. `busy` then stays high for exactly GUARD_CYC = ceil(GUARD_US·CLK_HZ/10^6) cycles with `zz_n` high.
- R9: An exit request that arrives while the entry hold is still running is remembered. `zz_n` stays low for the full ENTRY_CYC cycles plus one power-down cycle, and recovery then follows with no further request.
- R10: `data_invalid` goes to 1 at the edge where the power-down state is reached and stays at 1 until `inval_clr` is sampled high. A set in the same cycle as a clear wins.
- R11: A `cfg_wr` while `busy`=1 leaves `rcr_q` unchanged.
- R12: An exit request outside the entry hold and the power-down state has no effect. An entry request while `busy`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the shadow refresh configuration |
| cfg_wdata | input | RCR_W | Value to load |
| rcr_q | output | RCR_W | Shadow refresh configuration |
| tcsr_sel | output | 2 | Temperature-compensated refresh range |
| refr_words | output | ADDR_W+1 | Number of words still refreshed |
| dpd_enter_req | input | 1 | Request entry into deep power-down |
| dpd_exit_req | input | 1 | Request exit from deep power-down |
| inval_clr | input | 1 | Clear the data-invalid flag |
| zz_n | output | 1 | Active-low sleep pin to the memory |
| busy | output | 1 | Sequence in progress, commands blocked |
| dpd_refused | output | 1 | One-cycle pulse: entry refused |
| data_invalid | output | 1 | Array contents lost, sticky |
| host_cmd_valid | input | 1 | Host command request |
| host_cmd | input | CMD_W | Host command code |
| host_cmd_ready | output | 1 | Host command accepted |
| mem_cmd_valid | output | 1 | Command to the memory (0 = deselect) |
| mem_cmd | output | CMD_W | Command code to the memory |

## Verification
The bench scales CLK_HZ down to 20 MHz so that both windows fit in a short run. The timing checks measure the low time of the sleep pin and the recovery window to the exact cycle. A design that releases the pin one cycle early, or that drops the extra margin cycle, gives a count that is one short. The bench sends an exit request in the middle of the entry hold. A design that releases the pin at once fails the low-time count, and one that forgets the request never reaches recovery. The bench also writes the configuration and sends a second entry request while busy, and it offers commands during the whole sequence, so a leak of either shows up as a changed shadow or a non-deselect command.

// File: rtl/dpd_seq_pkg.sv
package dpd_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_ENABLED    = 3'd1,
      ST_ZZ_WAIT    = 3'd2,
      ST_DPD        = 3'd3,
      ST_EXIT_GUARD = 3'd4,
      ST_READY      = 3'd5
   } dpd_state_e;

   localparam int CFG_EN_BIT    = 4;
   localparam int CFG_ARR_LSB   = 0;
   localparam int CFG_ARR_W     = 3;
   localparam int CFG_TEMP_LSB  = 5;
   localparam int CFG_TEMP_W    = 2;

   function automatic longint us_to_cycles(input longint hz, input longint us);
      return (hz * us + 64'd999_999) / 64'd1_000_000;
   endfunction
endpackage

// File: rtl/dpd_rcr_shadow.sv
module dpd_rcr_shadow
   import dpd_seq_pkg::*;
#(
   parameter int               RCR_W   = 8,
   parameter int               ADDR_W  = 21,
   parameter logic [RCR_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RCR_W-1:0]  wdata,
   output logic [RCR_W-1:0]  cfg_q,
   output logic              en_now,
   output logic              en_next,
   output logic [CFG_TEMP_W-1:0] temp_sel,
   output logic [ADDR_W:0]   words
);
   localparam int NCODES = 1 << CFG_ARR_W;
   localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;

   logic [ADDR_W:0] lim [NCODES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= RST_VAL;
      else if (wr_en) cfg_q <= wdata;
   end

   // Fraction table: halve per code up to one eighth, then nothing refreshed.
   for (genvar c = 0; c < NCODES; c++) begin : g_code
      if (c < 4) begin : g_part
         assign lim[c] = FULL >> c;
      end else begin : g_none
         assign lim[c] = '0;
      end
   end

   assign en_now   = cfg_q[CFG_EN_BIT];
   assign en_next  = wr_en ? wdata[CFG_EN_BIT] : cfg_q[CFG_EN_BIT];
   assign temp_sel = cfg_q[CFG_TEMP_LSB +: CFG_TEMP_W];
   assign words    = lim[cfg_q[CFG_ARR_LSB +: CFG_ARR_W]];
endmodule

// File: rtl/dpd_interval_timer.sv
module dpd_interval_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   // Last counted cycle of the window: the owner moves on at this edge.
   assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dpd_cmd_gate.sv
module dpd_cmd_gate #(
   parameter int CMD_W = 4
) (
   input  logic             block,
   input  logic             host_valid,
   input  logic [CMD_W-1:0] host_cmd,
   output logic             host_ready,
   output logic             mem_valid,
   output logic [CMD_W-1:0] mem_cmd
);
   assign host_ready = !block;
   assign mem_valid  = host_valid && !block;
   assign mem_cmd    = block ? '0 : host_cmd;
endmodule

// File: rtl/psram_dpd_seq.sv
module psram_dpd_seq
   import dpd_seq_pkg::*;
#(
   parameter int               CLK_HZ   = 200_000_000,
   parameter int               ENTRY_US = 10,
   parameter int               GUARD_US = 150,
   parameter int               ADDR_W   = 21,
   parameter int               CMD_W    = 4,
   parameter int               RCR_W    = 8,
   parameter logic [RCR_W-1:0] RCR_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [RCR_W-1:0]  cfg_wdata,
   output logic [RCR_W-1:0]  rcr_q,
   output logic [1:0]        tcsr_sel,
   output logic [ADDR_W:0]   refr_words,
   input  logic              dpd_enter_req,
   input  logic              dpd_exit_req,
   input  logic              inval_clr,
   output logic              zz_n,
   output logic              busy,
   output logic              dpd_refused,
   output logic              data_invalid,
   input  logic              host_cmd_valid,
   input  logic [CMD_W-1:0]  host_cmd,
   output logic              host_cmd_ready,
   output logic              mem_cmd_valid,
   output logic [CMD_W-1:0]  mem_cmd
);
   localparam int ENTRY_CYC = int'(us_to_cycles(CLK_HZ, ENTRY_US)) + 1;
   localparam int GUARD_CYC = int'(us_to_cycles(CLK_HZ, GUARD_US));
   localparam int MAX_CYC   = (ENTRY_CYC > GUARD_CYC) ? ENTRY_CYC : GUARD_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] ENTRY_CNT = CNT_W'(ENTRY_CYC);
   localparam logic [CNT_W-1:0] GUARD_CNT = CNT_W'(GUARD_CYC);

   if (CLK_HZ < 1_000_000) begin : g_chk_clk
      $error("psram_dpd_seq: CLK_HZ must be at least 1 MHz");
   end
   if (RCR_W < CFG_TEMP_LSB + CFG_TEMP_W) begin : g_chk_rcr
      $error("psram_dpd_seq: RCR_W too narrow for the temperature field");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("psram_dpd_seq: ADDR_W must be at least 3");
   end
   if (ENTRY_CYC < 2 || GUARD_CYC < 2) begin : g_chk_win
      $error("psram_dpd_seq: timing windows must span at least two cycles");
   end
   if (CMD_W < 1) begin : g_chk_cmd
      $error("psram_dpd_seq: CMD_W must be positive");
   end

   dpd_state_e       state_q, state_d;
   logic             quiet;
   logic             en_now, en_next;
   logic             wr_en;
   logic             tmr_load, tmr_expire;
   logic [CNT_W-1:0] tmr_val;
   logic             exit_pend_q;
   logic             reach_dpd;

   assign quiet = (state_q == ST_IDLE) || (state_q == ST_ENABLED) || (state_q == ST_READY);
   assign wr_en = cfg_wr && quiet;

   dpd_rcr_shadow #(
      .RCR_W   (RCR_W),
      .ADDR_W  (ADDR_W),
      .RST_VAL (RCR_RST)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wdata    (cfg_wdata),
      .cfg_q    (rcr_q),
      .en_now   (en_now),
      .en_next  (en_next),
      .temp_sel (tcsr_sel),
      .words    (refr_words)
   );

   dpd_interval_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE, ST_ENABLED, ST_READY: begin
            if (dpd_enter_req && en_now) begin
               state_d  = ST_ZZ_WAIT;
               tmr_load = 1'b1;
               tmr_val  = ENTRY_CNT;
            end else begin
               state_d = en_next ? ST_ENABLED : ST_IDLE;
            end
         end
         ST_ZZ_WAIT: begin
            if (tmr_expire) state_d = ST_DPD;
         end
         ST_DPD: begin
            if (dpd_exit_req || exit_pend_q) begin
               state_d  = ST_EXIT_GUARD;
               tmr_load = 1'b1;
               tmr_val  = GUARD_CNT;
            end
         end
         ST_EXIT_GUARD: begin
            if (tmr_expire) state_d = ST_READY;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign reach_dpd = (state_q == ST_ZZ_WAIT) && tmr_expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         exit_pend_q  <= 1'b0;
         dpd_refused  <= 1'b0;
         data_invalid <= 1'b0;
      end else begin
         state_q     <= state_d;
         dpd_refused <= quiet && dpd_enter_req && !en_now;
         if (state_q == ST_ZZ_WAIT)
            exit_pend_q <= exit_pend_q || dpd_exit_req;
         else
            exit_pend_q <= 1'b0;
         if (reach_dpd)      data_invalid <= 1'b1;
         else if (inval_clr) data_invalid <= 1'b0;
      end
   end

   assign zz_n = !((state_q == ST_ZZ_WAIT) || (state_q == ST_DPD));
   assign busy = (state_q == ST_ZZ_WAIT) || (state_q == ST_DPD) || (state_q == ST_EXIT_GUARD);

   dpd_cmd_gate #(
      .CMD_W (CMD_W)
   ) u_gate (
      .block      (busy),
      .host_valid (host_cmd_valid),
      .host_cmd   (host_cmd),
      .host_ready (host_cmd_ready),
      .mem_valid  (mem_cmd_valid),
      .mem_cmd    (mem_cmd)
   );
endmodule

// File: rtl/psram_dpd_seq_chk.sv
module psram_dpd_seq_chk #(
   parameter int ENTRY_CYC = 2,
   parameter int GUARD_CYC = 2,
   parameter int RCR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zz_n,
   input  logic             busy,
   input  logic             host_cmd_ready,
   input  logic             mem_cmd_valid,
   input  logic             dpd_refused,
   input  logic             data_invalid,
   input  logic             inval_clr,
   input  logic [RCR_W-1:0] rcr_q
);
   int low_run;
   int guard_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run   <= 0;
         guard_run <= 0;
      end else begin
         if (!zz_n) low_run <= low_run + 1;
         else       low_run <= 0;
         if (busy && zz_n) guard_run <= guard_run + 1;
         else if (!busy)   guard_run <= 0;
      end
   end

   // R5: the sleep pin is never low outside a busy sequence
   a_r5_zz_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !zz_n |-> busy);

   // R5: the pin is released only after the full entry hold
   a_r5_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      (zz_n && low_run != 0) |-> low_run >= ENTRY_CYC);

   // R7: while busy the memory sees only deselect and the host is stalled
   a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!mem_cmd_valid && !host_cmd_ready));

   // R8: recovery never ends before the guard window has run out
   a_r8_guard_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && guard_run != 0) |-> guard_run >= GUARD_CYC);

   // R8: releasing the pin starts recovery, not idle
   a_r8_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zz_n) |-> busy);

   // R4: a refusal leaves the pin high
   a_r4_refuse_high: assert property (@(posedge clk) disable iff (!rst_n)
      dpd_refused |-> zz_n);

   // R10: the flag holds until cleared
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (data_invalid && !inval_clr) |=> data_invalid);

   // R10: the flag is raised only with the pin low
   a_r10_set_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_invalid) |-> !zz_n);

   // R11: configuration is frozen while busy
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rcr_q));
endmodule

bind psram_dpd_seq psram_dpd_seq_chk #(
   .ENTRY_CYC (ENTRY_CYC),
   .GUARD_CYC (GUARD_CYC),
   .RCR_W     (RCR_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .zz_n           (zz_n),
   .busy           (busy),
   .host_cmd_ready (host_cmd_ready),
   .mem_cmd_valid  (mem_cmd_valid),
   .dpd_refused    (dpd_refused),
   .data_invalid   (data_invalid),
   .inval_clr      (inval_clr),
   .rcr_q          (rcr_q)
);

// File: tb/psram_dpd_seq_tb.sv
`timescale 1ns/1ps
module psram_dpd_seq_tb;
   localparam int     CLK_HZ = 20_000_000;
   localparam int     AW     = 21;
   localparam int     CW     = 4;
   localparam longint T_ENTRY = (longint'(10) * CLK_HZ + 999_999) / 1_000_000 + 1;
   localparam longint T_GUARD = (longint'(150) * CLK_HZ + 999_999) / 1_000_000;

   logic clk = 0;
   logic rst_n = 0;
   logic cfg_wr = 0;
   logic [7:0] cfg_wdata = 0;
   logic [7:0] rcr_q;
   logic [1:0] tcsr_sel;
   logic [AW:0] refr_words;
   logic dpd_enter_req = 0, dpd_exit_req = 0, inval_clr = 0;
   logic zz_n, busy, dpd_refused, data_invalid;
   logic host_cmd_valid = 0;
   logic [CW-1:0] host_cmd = 0;
   logic host_cmd_ready, mem_cmd_valid;
   logic [CW-1:0] mem_cmd;

   always #2.5 clk = ~clk;

   psram_dpd_seq #(.CLK_HZ(CLK_HZ), .ADDR_W(AW), .CMD_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .rcr_q(rcr_q), .tcsr_sel(tcsr_sel), .refr_words(refr_words),
      .dpd_enter_req(dpd_enter_req), .dpd_exit_req(dpd_exit_req),
      .inval_clr(inval_clr), .zz_n(zz_n), .busy(busy),
      .dpd_refused(dpd_refused), .data_invalid(data_invalid),
      .host_cmd_valid(host_cmd_valid), .host_cmd(host_cmd),
      .host_cmd_ready(host_cmd_ready), .mem_cmd_valid(mem_cmd_valid),
      .mem_cmd(mem_cmd));

   int checks = 0;
   int failures = 0;
   longint cycles = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // R3: words refreshed per array code, from the requirement
   function automatic longint exp_words(input int code);
      return (code < 4) ? ((longint'(1) << AW) >> code) : 0;
   endfunction

   // Behavioural reference: phase 0 quiet, 1 entry hold, 2 powered down, 3 recovery
   int     m_ph = 0;
   longint m_left = 0;
   bit     m_pend = 0, m_inv = 0, m_ref = 0;
   logic [7:0] m_cfg = 0;

   always @(posedge clk) begin
      bit old_en, set_inv;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_pend = 0; m_inv = 0; m_ref = 0; m_cfg = 0;
      end else begin
         m_ref = 0; set_inv = 0;
         case (m_ph)
            0: begin
               old_en = m_cfg[4];
               if (cfg_wr) m_cfg = cfg_wdata;
               if (dpd_enter_req) begin
                  if (old_en) begin m_ph = 1; m_left = T_ENTRY; m_pend = 0; end
                  else m_ref = 1;
               end
            end
            1: begin
               if (dpd_exit_req) m_pend = 1;
               m_left--;
               if (m_left == 0) begin m_ph = 2; set_inv = 1; end
            end
            2: if (dpd_exit_req || m_pend) begin m_ph = 3; m_left = T_GUARD; m_pend = 0; end
            default: begin
               m_left--;
               if (m_left == 0) m_ph = 0;
            end
         endcase
         if (set_inv) m_inv = 1;
         else if (inval_clr) m_inv = 0;
      end
   end

   // Per-cycle comparison plus run-length measurement, away from the active edge
   longint low_run = 0, last_low = 0, g_run = 0, last_guard = 0, p_run = 0, last_pre = 0;

   always @(negedge clk) begin
      bit e_busy;
      cycles++;
      if (rst_n) begin
         e_busy = (m_ph != 0);
         chk(zz_n == !(m_ph == 1 || m_ph == 2), "R5", "zz_n", zz_n, !(m_ph == 1 || m_ph == 2));
         chk(busy == e_busy, "R5", "busy", busy, e_busy);
         chk(dpd_refused == m_ref, "R4", "dpd_refused", dpd_refused, m_ref);
         chk(data_invalid == m_inv, "R10", "data_invalid", data_invalid, m_inv);
         chk(host_cmd_ready == !e_busy, "R7", "host_cmd_ready", host_cmd_ready, !e_busy);
         chk(mem_cmd_valid == (host_cmd_valid && !e_busy), "R6", "mem_cmd_valid",
             mem_cmd_valid, host_cmd_valid && !e_busy);
         chk(mem_cmd == (e_busy ? '0 : host_cmd), "R7", "mem_cmd", mem_cmd, e_busy ? 0 : host_cmd);
         chk(rcr_q == m_cfg, "R2", "rcr_q", rcr_q, m_cfg);
         chk(tcsr_sel == m_cfg[6:5], "R2", "tcsr_sel", tcsr_sel, m_cfg[6:5]);
         chk(refr_words == exp_words(int'(m_cfg[2:0])), "R3", "refr_words",
             refr_words, exp_words(int'(m_cfg[2:0])));
      end
      if (!zz_n) low_run++;
      else if (low_run != 0) begin last_low = low_run; low_run = 0; end
      if (busy && zz_n) g_run++;
      else if (!busy && g_run != 0) begin last_guard = g_run; g_run = 0; end
      if (!zz_n && !data_invalid) p_run++;
      else if (data_invalid && p_run != 0) begin last_pre = p_run; p_run = 0; end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_wr = 1; cfg_wdata = v; step(); cfg_wr = 0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      settle();
      // R1: reset state
      chk(zz_n == 1 && busy == 0 && data_invalid == 0 && dpd_refused == 0, "R1", "status",
          {zz_n, busy, data_invalid, dpd_refused}, 4'b1000);
      chk(host_cmd_ready == 1 && rcr_q == 8'h00, "R1", "ready/cfg", {host_cmd_ready, rcr_q}, 9'h100);
      step();

      // R6: pass-through while idle
      host_cmd_valid = 1; host_cmd = 4'hA;
      settle();
      chk(mem_cmd_valid && mem_cmd == 4'hA && host_cmd_ready, "R6", "pass-through",
          {mem_cmd_valid, mem_cmd}, 5'h1A);
      step(); host_cmd_valid = 0;

      // R4: entry without the enable bit
      dpd_enter_req = 1; step(); dpd_enter_req = 0;
      settle();
      chk(dpd_refused == 1 && zz_n == 1, "R4", "refused", {dpd_refused, zz_n}, 2'b11);
      step();
      settle();
      chk(dpd_refused == 0, "R4", "refused one cycle", dpd_refused, 0);
      step();

      // R12: exit while idle has no effect
      dpd_exit_req = 1; step(); dpd_exit_req = 0;
      settle();
      chk(zz_n == 1 && busy == 0, "R12", "stray exit", {zz_n, busy}, 2'b10);
      step();

      // R2 and R3: every array code with varied temperature field
      for (int c = 0; c < 8; c++) begin
         logic [7:0] v;
         v = {1'b1, c[1:0], 2'b01, c[2:0]} & 8'hEF;
         write_cfg(v);
         settle();
         chk(rcr_q == v, "R2", "cfg load", rcr_q, v);
         chk(tcsr_sel == c[1:0], "R2", "temp field", tcsr_sel, c[1:0]);
         chk(refr_words == exp_words(c), "R3", "array words", refr_words, exp_words(c));
         step();
      end

      // Enable with array code 010: lowest quarter refreshed
      write_cfg(8'h12);
      settle();
      chk(refr_words == 22'h080000, "R3", "code 010 words", refr_words, 22'h080000);
      step();

      // R5 and R7: entry with commands pending
      host_cmd_valid = 1; host_cmd = 4'h5;
      dpd_enter_req = 1; step(); dpd_enter_req = 0;
      settle();
      chk(zz_n == 0 && busy == 1, "R5", "entry start", {zz_n, busy}, 2'b01);
      chk(!mem_cmd_valid && !host_cmd_ready && mem_cmd == 0, "R7", "deselect",
          {mem_cmd_valid, host_cmd_ready, mem_cmd}, 0);
      step();
      // R11: write while busy ignored; R12: second entry ignored
      write_cfg(8'h00);
      dpd_enter_req = 1; step(); dpd_enter_req = 0;
      settle();
      chk(rcr_q == 8'h12, "R11", "cfg frozen", rcr_q, 8'h12);
      chk(busy == 1 && zz_n == 0, "R12", "entry while busy", {busy, zz_n}, 2'b10);
      step();
      while (!data_invalid) step();
      settle();
      chk(last_pre == T_ENTRY, "R5", "entry hold cycles", last_pre, T_ENTRY);
      chk(data_invalid == 1, "R10", "set on entry", data_invalid, 1);
      step();
      repeat (20) step();
      chk(zz_n == 0, "R8", "holds low without exit", zz_n, 0);

      // R8: exit and guard window
      dpd_exit_req = 1; step(); dpd_exit_req = 0;
      settle();
      chk(zz_n == 1 && busy == 1, "R8", "exit start", {zz_n, busy}, 2'b11);
      step();
      while (busy) step();
      settle();
      chk(last_guard == T_GUARD, "R8", "guard cycles", last_guard, T_GUARD);
      chk(host_cmd_ready == 1 && mem_cmd_valid == 1 && mem_cmd == 4'h5, "R7", "stalled command released",
          {host_cmd_ready, mem_cmd_valid, mem_cmd}, 6'h35);
      chk(data_invalid == 1, "R10", "sticky after exit", data_invalid, 1);
      step();
      inval_clr = 1; step(); inval_clr = 0;
      settle();
      chk(data_invalid == 0, "R10", "cleared", data_invalid, 0);
      step();

      // R9: exit requested during the entry hold
      dpd_enter_req = 1; step(); dpd_enter_req = 0;
      repeat (5) step();
      dpd_exit_req = 1; step(); dpd_exit_req = 0;
      settle();
      chk(zz_n == 0, "R9", "no early release", zz_n, 0);
      step();
      while (!zz_n) step();
      settle();
      chk(last_low == T_ENTRY + 1, "R9", "deferred low cycles", last_low, T_ENTRY + 1);
      chk(busy == 1, "R9", "recovery follows", busy, 1);
      step();
      while (busy) step();
      settle();
      chk(last_guard == T_GUARD, "R9", "guard after deferred exit", last_guard, T_GUARD);
      step();
      host_cmd_valid = 0;
      repeat (3) step();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 60000);
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule